// File: doc/BRIEF.md
# Mode-Aware Bidirectional GPIO Port

This block controls one byte-wide general-purpose I/O port behind a small memory-mapped register bus. Software sets the direction of each pin, the value it drives and whether a weak pull-up is wanted. A separate read-only location returns the pad levels after a two-flop synchronizer. The block produces per-pin drive value, drive enable and pull-up enable toward the pad cells. It holds no pad logic of its own.

In the expanded operating modes the external bus controller may take over low-order pins as address outputs. A 4-bit address-enable field says how many pins, counted up from bit 0, carry address lines. In the single-chip mode every pin stays plain I/O and the field is ignored.

The block also applies the chip-level reset and low-power rules. A power-on reset and hardware standby clear the registers. A manual reset keeps the direction register. Software standby keeps all registers, and a hold-enable bit decides whether the address pins keep driving or float while standby lasts.

Top module: `gpio_port_ctl`

## Requirements
- R1: After a power-on reset (`rst`), the direction, data and pull-up registers are 0x00. `pad_oe`, `pad_out` and `pu_en` are all 0, and the data and pull-up locations read 0x00.
- R2: With no address override, pin i has `pad_oe[i]` equal to direction bit i (1 = output) and `pad_out[i]` equal to data bit i.
- R3: The direction register (offset 0xFE3A) is write-only. A read of that offset returns 0x00.
- R4: The data register (offset 0xFF0A) and the pull-up register (offset 0xFE41) read back the last value written. Read data appears on `rdata` one cycle after `rd_en`.
- R5: A read of the pin-state location (offset 0xFFBA) returns `pad_in` as seen through a two-flop synchronizer.
- R6: In the expanded modes (`mode` = 4, 5 or 6), each pin i with i < `addr_en` drives `ext_addr[i]` with `pad_oe[i]` = 1, whatever its direction bit holds. Codes of 8 or more select all pins.
- R7: In the expanded modes, each pin i with i >= `addr_en` behaves as in R2.
- R8: In any mode code other than 4, 5 or 6 (single-chip is 7), `addr_en` has no effect and every pin behaves as in R2.
- R9: `pu_en[i]` is 1 only when pull-up bit i is 1, pin i is an input and pin i is not an address output.
- R10: A manual reset (`manual_rst`) clears the data and pull-up registers, keeps the direction register, and blocks any write made in the same cycle.
- R11: While `hw_stby` is 1, all three registers are cleared, writes are blocked, and `pad_oe` and `pu_en` are 0.
- R12: While `sw_stby` is 1, all registers keep their contents. The set of address pins is frozen at its value on entry. If `stby_hold` is 1, those pins keep their last drive value and enable.
- R13: While `sw_stby` is 1 with `stby_hold` at 0, the frozen address pins have `pad_oe` = 0. The other pins still follow R2.
- R14: A write to an offset that is not mapped changes no register, and a read of such an offset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| manual_rst | input | 1 | Synchronous manual reset; the direction register is kept |
| hw_stby | input | 1 | Hardware standby level |
| sw_stby | input | 1 | Software standby level |
| stby_hold | input | 1 | 1: address pins keep driving in software standby; 0: they float |
| mode | input | 3 | Operating mode code; 4 to 6 are expanded, 7 is single-chip |
| addr_en | input | 4 | Number of low-order pins used as address outputs |
| ext_addr | input | 8 | Address bits from the external bus controller |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 16 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_out | output | 8 | Per-pin drive value (registered) |
| pad_oe | output | 8 | Per-pin drive enable (registered) |
| pu_en | output | 8 | Per-pin pull-up enable (registered) |

## Verification
The bench uses the default build: an 8-bit port, a 4-bit address-enable field and two synchronizer stages. At this size it can sweep all eight mode codes against all sixteen address-enable codes, and every pad input pattern through the pin-state location, with each expected byte computed arithmetically.

This coverage includes the points where the address field reaches and passes the port width. It also includes the single-chip and undefined mode codes that must ignore the field. Directed sequences then cover manual reset, both standby kinds and both settings of the hold bit.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_DIR  = 3'd1,
    SEL_DATA = 3'd2,
    SEL_PIN  = 3'd3,
    SEL_PULL = 3'd4
  } reg_sel_e;

  localparam logic [2:0] MODE_SINGLE_CHIP = 3'd7;

  function automatic logic mode_is_expanded(input logic [2:0] m);
    return (m == 3'd4) || (m == 3'd5) || (m == 3'd6);
  endfunction

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int             WIDTH    = 8,
  parameter int             AW       = 16,
  parameter logic [AW-1:0]  DIR_OFF  = 'hFE3A,
  parameter logic [AW-1:0]  DATA_OFF = 'hFF0A,
  parameter logic [AW-1:0]  PIN_OFF  = 'hFFBA,
  parameter logic [AW-1:0]  PULL_OFF = 'hFE41
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             manual_rst,
  input  logic             hw_stby,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] pull_q,
  output logic [WIDTH-1:0] rdata
);

  reg_sel_e sel;

  always_comb begin
    if      (addr == DIR_OFF)  sel = SEL_DIR;
    else if (addr == DATA_OFF) sel = SEL_DATA;
    else if (addr == PIN_OFF)  sel = SEL_PIN;
    else if (addr == PULL_OFF) sel = SEL_PULL;
    else                       sel = SEL_NONE;
  end

  // Clear priority: power-on reset, hardware standby, manual reset, write.
  always_ff @(posedge clk) begin
    if (rst || hw_stby) begin
      dir_q  <= '0;
      data_q <= '0;
      pull_q <= '0;
    end else if (manual_rst) begin
      data_q <= '0;
      pull_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DIR:  dir_q  <= wdata;
        SEL_DATA: data_q <= wdata;
        SEL_PULL: pull_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (sel)
        SEL_DATA: rdata <= data_q;
        SEL_PULL: rdata <= pull_q;
        SEL_PIN:  rdata <= pin_sync;
        default:  rdata <= '0;
      endcase
    end
  end

  // R10
  dir_kept_mrst_chk: assert property (@(posedge clk) disable iff (rst)
    (manual_rst && !hw_stby) |=> (dir_q == $past(dir_q)));

  // R11
  hw_stby_clear_chk: assert property (@(posedge clk) disable iff (rst)
    hw_stby |=> (dir_q == '0 && data_q == '0 && pull_q == '0));

  // R3
  dir_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == DIR_OFF) |=> (rdata == '0));

endmodule

// File: rtl/gpio_port_pinmux.sv
module gpio_port_pinmux
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int AE_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  logic [AE_W-1:0]  addr_en,
  input  logic [WIDTH-1:0] ext_addr,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] data,
  input  logic [WIDTH-1:0] pull,
  input  logic             hw_stby,
  input  logic             sw_stby,
  input  logic             stby_hold,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pu_en
);

  logic             expanded;
  logic [WIDTH-1:0] amask_live;
  logic [WIDTH-1:0] amask_q;
  logic [WIDTH-1:0] amask_use;
  logic [WIDTH-1:0] out_d, oe_d, pu_d;

  assign expanded = mode_is_expanded(mode);

  // Thermometer map: pin i is an address output when i < addr_en.
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_mask
      assign amask_live[i] = expanded && (i < int'(addr_en));
    end
  endgenerate

  // The address-pin set is frozen for the whole of software standby.
  always_ff @(posedge clk) begin
    if (rst)           amask_q <= '0;
    else if (!sw_stby) amask_q <= amask_live;
  end

  assign amask_use = sw_stby ? amask_q : amask_live;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      always_comb begin
        if (hw_stby) begin
          out_d[i] = 1'b0;
          oe_d[i]  = 1'b0;
          pu_d[i]  = 1'b0;
        end else if (amask_use[i]) begin
          pu_d[i] = 1'b0;
          if (sw_stby) begin
            out_d[i] = pad_out[i];
            oe_d[i]  = stby_hold ? pad_oe[i] : 1'b0;
          end else begin
            out_d[i] = ext_addr[i];
            oe_d[i]  = 1'b1;
          end
        end else begin
          out_d[i] = data[i];
          oe_d[i]  = dir[i];
          pu_d[i]  = pull[i] & ~dir[i];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      pu_en   <= '0;
    end else begin
      pad_out <= out_d;
      pad_oe  <= oe_d;
      pu_en   <= pu_d;
    end
  end

  // R9
  pull_only_input_chk: assert property (@(posedge clk) disable iff (rst)
    ((pu_en & pad_oe) == '0));

  // R9
  pull_needs_bit_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pu_en & ~$past(pull)) == '0));

  // R11
  hw_stby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    hw_stby |=> (pad_oe == '0 && pu_en == '0));

  // R12
  sw_stby_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(sw_stby) && $past(stby_hold) && !$past(hw_stby) && !$past(rst))
      |-> (((pad_out & amask_q) == ($past(pad_out) & amask_q)) &&
           ((pad_oe & amask_q) == ($past(pad_oe) & amask_q))));

  // R13
  sw_stby_float_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(sw_stby) && !$past(stby_hold) && !$past(rst))
      |-> ((pad_oe & amask_q) == '0));

endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl #(
  parameter int            WIDTH       = 8,
  parameter int            AW          = 16,
  parameter int            AE_W        = 4,
  parameter int            SYNC_STAGES = 2,
  parameter logic [AW-1:0] DIR_OFF     = 'hFE3A,
  parameter logic [AW-1:0] DATA_OFF    = 'hFF0A,
  parameter logic [AW-1:0] PIN_OFF     = 'hFFBA,
  parameter logic [AW-1:0] PULL_OFF    = 'hFE41
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             manual_rst,
  input  logic             hw_stby,
  input  logic             sw_stby,
  input  logic             stby_hold,
  input  logic [2:0]       mode,
  input  logic [AE_W-1:0]  addr_en,
  input  logic [WIDTH-1:0] ext_addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pu_en
);

  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] dir_q, data_q, pull_q;

  gpio_port_sync #(
    .WIDTH  (WIDTH),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  gpio_port_regs #(
    .WIDTH    (WIDTH),
    .AW       (AW),
    .DIR_OFF  (DIR_OFF),
    .DATA_OFF (DATA_OFF),
    .PIN_OFF  (PIN_OFF),
    .PULL_OFF (PULL_OFF)
  ) regs_i (
    .clk        (clk),
    .rst        (rst),
    .manual_rst (manual_rst),
    .hw_stby    (hw_stby),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .pin_sync   (pin_sync),
    .dir_q      (dir_q),
    .data_q     (data_q),
    .pull_q     (pull_q),
    .rdata      (rdata)
  );

  gpio_port_pinmux #(
    .WIDTH (WIDTH),
    .AE_W  (AE_W)
  ) mux_i (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .addr_en   (addr_en),
    .ext_addr  (ext_addr),
    .dir       (dir_q),
    .data      (data_q),
    .pull      (pull_q),
    .hw_stby   (hw_stby),
    .sw_stby   (sw_stby),
    .stby_hold (stby_hold),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pu_en     (pu_en)
  );

endmodule

// File: tb/gpio_port_ctl_tb.sv
`timescale 1ns/1ps
module gpio_port_ctl_tb_top;

  localparam logic [15:0] A_DIR  = 16'hFE3A;
  localparam logic [15:0] A_DATA = 16'hFF0A;
  localparam logic [15:0] A_PIN  = 16'hFFBA;
  localparam logic [15:0] A_PULL = 16'hFE41;
  localparam logic [15:0] A_BAD  = 16'h1234;

  logic        clk = 1'b0;
  logic        rst, manual_rst, hw_stby, sw_stby, stby_hold;
  logic [2:0]  mode;
  logic [3:0]  addr_en;
  logic [7:0]  ext_addr;
  logic        wr_en, rd_en;
  logic [15:0] addr;
  logic [7:0]  wdata, rdata, pad_in, pad_out, pad_oe, pu_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port_ctl dut_i (
    .clk (clk), .rst (rst), .manual_rst (manual_rst), .hw_stby (hw_stby),
    .sw_stby (sw_stby), .stby_hold (stby_hold), .mode (mode),
    .addr_en (addr_en), .ext_addr (ext_addr), .wr_en (wr_en), .rd_en (rd_en),
    .addr (addr), .wdata (wdata), .rdata (rdata), .pad_in (pad_in),
    .pad_out (pad_out), .pad_oe (pad_oe), .pu_en (pu_en)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst = 1'b1; manual_rst = 1'b0; hw_stby = 1'b0; sw_stby = 1'b0;
    stby_hold = 1'b0; mode = 3'd7; addr_en = 4'd0; ext_addr = 8'h00;
    wr_en = 1'b0; rd_en = 1'b0; addr = 16'h0; wdata = 8'h00; pad_in = 8'h00;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);

    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 pu_en", pu_en, 8'h00);
    rd(A_DATA, v); check("R1 data", v, 8'h00);
    rd(A_PULL, v); check("R1 pull", v, 8'h00);

    // R3 direction is write-only
    wr(A_DIR, 8'hFF);
    rd(A_DIR, v); check("R3 dir read", v, 8'h00);
    wait_cyc(1);
    check("R2 oe after dir write", pad_oe, 8'hFF);
    wr(A_DIR, 8'h00);

    // R4 readback, R14 unmapped
    wr(A_DATA, 8'h3C);
    wr(A_PULL, 8'hA5);
    rd(A_DATA, v); check("R4 data", v, 8'h3C);
    rd(A_PULL, v); check("R4 pull", v, 8'hA5);
    wr(A_BAD, 8'hFF);
    rd(A_BAD, v); check("R14 unmapped read", v, 8'h00);
    rd(A_DATA, v); check("R14 data untouched", v, 8'h3C);
    rd(A_PULL, v); check("R14 pull untouched", v, 8'hA5);
    wait_cyc(1);
    check("R14 oe untouched", pad_oe, 8'h00);

    // R5 pin-state sweep over every pattern
    for (int p = 0; p < 256; p++) begin
      pad_in = p[7:0];
      wait_cyc(2);
      rd(A_PIN, v);
      check("R5 pin state", v, p[7:0]);
    end

    // R2 R6 R7 R8 R9 sweep over every mode and address-enable code
    for (int m = 0; m < 8; m++) begin
      for (int a = 0; a < 16; a++) begin
        logic [7:0] d_dir, d_dat, d_pul, d_adr, am, e_out, e_oe, e_pu;
        d_dir = 8'hC3 ^ 8'(a << 2) ^ 8'(m);
        d_dat = 8'h5A ^ 8'(m * 37) ^ 8'(a);
        d_pul = 8'hF0 ^ 8'(a * 11);
        d_adr = ~d_dat ^ 8'(m << 5);
        mode = m[2:0]; addr_en = a[3:0]; ext_addr = d_adr;
        wr(A_DIR, d_dir); wr(A_DATA, d_dat); wr(A_PULL, d_pul);
        wait_cyc(2);
        for (int b = 0; b < 8; b++)
          am[b] = (m >= 4 && m <= 6) && (b < a);
        e_out = (d_adr & am) | (d_dat & ~am);
        e_oe  = am | d_dir;
        e_pu  = d_pul & ~d_dir & ~am;
        if (m >= 4 && m <= 6) begin
          check("R6/R7 pad_out", pad_out, e_out);
          check("R6/R7 pad_oe", pad_oe, e_oe);
        end else begin
          check("R8/R2 pad_out", pad_out, e_out);
          check("R8/R2 pad_oe", pad_oe, e_oe);
        end
        check("R9 pu_en", pu_en, e_pu);
      end
    end

    // R10 manual reset
    mode = 3'd7; addr_en = 4'd0;
    wr(A_DIR, 8'h0F); wr(A_DATA, 8'hFF); wr(A_PULL, 8'hF0);
    addr = A_DIR; wdata = 8'hFF; wr_en = 1'b1; manual_rst = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; manual_rst = 1'b0;
    wait_cyc(2);
    check("R10 dir kept", pad_oe, 8'h0F);
    check("R10 out cleared", pad_out, 8'h00);
    rd(A_DATA, v); check("R10 data cleared", v, 8'h00);
    rd(A_PULL, v); check("R10 pull cleared", v, 8'h00);

    // R11 hardware standby
    mode = 3'd4; addr_en = 4'd3; ext_addr = 8'hFF;
    wr(A_DATA, 8'h77); wr(A_PULL, 8'hF0);
    hw_stby = 1'b1;
    wait_cyc(2);
    check("R11 oe off", pad_oe, 8'h00);
    check("R11 pu off", pu_en, 8'h00);
    wr(A_DATA, 8'h55);
    hw_stby = 1'b0;
    mode = 3'd7;
    wait_cyc(2);
    check("R11 dir cleared", pad_oe, 8'h00);
    rd(A_DATA, v); check("R11 data cleared", v, 8'h00);
    rd(A_PULL, v); check("R11 pull cleared", v, 8'h00);

    // R12 software standby with hold
    mode = 3'd4; addr_en = 4'd4; ext_addr = 8'h05;
    wr(A_DIR, 8'hF0); wr(A_DATA, 8'hA0);
    wait_cyc(2);
    check("R6 before standby out", pad_out, 8'hA5);
    stby_hold = 1'b1; sw_stby = 1'b1;
    wait_cyc(1);
    ext_addr = 8'h0A; addr_en = 4'd0;
    wait_cyc(2);
    check("R12 held out", pad_out, 8'hA5);
    check("R12 held oe", pad_oe, 8'hFF);
    rd(A_DATA, v); check("R12 data kept", v, 8'hA0);

    // R13 software standby without hold
    stby_hold = 1'b0;
    wait_cyc(2);
    check("R13 float oe", pad_oe, 8'hF0);
    sw_stby = 1'b0; addr_en = 4'd4;
    wait_cyc(2);
    check("R12 resume out", pad_out, 8'hAA);
    check("R12 resume oe", pad_oe, 8'hFF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule